// File: doc/BRIEF.md
# Instruction Address Translation Buffer with Multiple-Match Detection

This block translates instruction fetch addresses. Seven ways compare the incoming virtual address and address-space identifier in parallel. A lookup succeeds only when exactly one way matches. It then returns the physical address and the 4-bit access-attribute code of that entry. When no way matches the block reports a miss. When two or more ways match it reports a multiple-match error, which the fetch unit turns into an exception.

Ways 0 to 3 form the hardware-refill group. Each holds four entries, selected by virtual address bits [13:12]. Ways 4, 5 and 6 each hold one entry that software loads freely. A 32-bit size-select word gives each way a 4-bit field at bits [4n+3:4n]. Only ways 4 and 5 use their field, to pick a page larger than 4 KB. Way 6 is a wired way and always maps one 4 KB page. A write port loads entries. A refill write ignores the requested way number and places the entry in the refill way that a round-robin pointer chooses. Results are registered and appear one cycle after the request.

Top module: `itlb`

## Requirements
- R1: `res_valid` is high exactly one cycle after a cycle with `lk_valid` high. In any cycle where `res_valid` is low, `res_hit`, `res_miss` and `res_multihit` are low and `res_paddr` and `res_attr` are zero. After reset `refill_way` is 0.
- R2: When exactly one way matches, `res_hit` is set. `res_paddr` is the entry's physical page bits above the page size followed by the virtual address bits below it. `res_attr` is the entry's attribute.
- R3: When no way matches, `res_miss` is set and `res_paddr` and `res_attr` are zero.
- R4: When two or more ways match, `res_multihit` is set, `res_hit` is low, and `res_paddr` and `res_attr` are zero.
- R5: An entry matches only if it has been written since reset, its stored identifier is non-zero, and the stored identifier equals `lk_asid`. An entry whose stored identifier is 0 never matches, even for a lookup with `lk_asid` of 0.
- R6: In ways 0 to 3, a write stores the entry at index `wr_vpn[1:0]` and replaces the entry held there. A lookup reads the entry at index `lk_vaddr[13:12]`.
- R7: Ways 4 and 5 use page log2 size 12 + 2*k, where k is bits [1:0] of field `cfg_pgsz[4n+3:4n]`. Bits [3:2] of the field are ignored. The tag compares `lk_vaddr[31:size]`.
- R8: Ways 0 to 3 and way 6 always use 4 KB pages, whatever their size-select fields hold.
- R9: When `wr_en` and `wr_refill` are both high, the entry goes to the refill way given by `refill_way`, and `wr_way` is ignored. `refill_way` counts 0,1,2,3,0 and advances once per refill write.
- R10: A write changes lookup results only from the next cycle on. A lookup in the same cycle as a write sees the old contents.
- R11: A non-refill write with `wr_way` equal to 7 changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual fetch address |
| lk_asid | input | 8 | Current address-space identifier |
| cfg_pgsz | input | 32 | Size-select fields, 4 bits per way |
| wr_en | input | 1 | Entry write strobe |
| wr_refill | input | 1 | Write goes to the round-robin refill way |
| wr_way | input | 3 | Target way for a non-refill write |
| wr_vpn | input | 20 | Virtual page number to store |
| wr_ppn | input | 20 | Physical page number to store |
| wr_asid | input | 8 | Address-space identifier to store |
| wr_attr | input | 4 | Attribute code to store |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | Exactly one way matched |
| res_miss | output | 1 | No way matched |
| res_multihit | output | 1 | More than one way matched |
| res_paddr | output | 32 | Translated physical address |
| res_attr | output | 4 | Attribute of the matching entry |
| refill_way | output | 2 | Refill way the next refill write will use |

## Verification
The assertions assume that every input holds a known value at each rising edge while reset is released. They also assume reset is deasserted away from a clock edge, because the one-cycle-later properties start from the first sampled edge after release. The bench changes every input only on the falling edge. It holds the write strobe low through reset. It also drives the size-select word only from the same step that issues a lookup, so a mid-cycle change can never alter a result already predicted. The random phase uses a small pool of page numbers and identifiers so that hits, misses, multiple matches, writes to way 7 and refills all occur often.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  localparam int VA_W      = 32;
  localparam int PG_MIN    = 12;
  localparam int VPN_W     = VA_W - PG_MIN;
  localparam int ASID_W    = 8;
  localparam int CA_W      = 4;
  localparam int WAY_W     = 3;
  localparam int NUM_WAYS  = 7;
  localparam int ARF_WAYS  = 4;
  localparam int ARF_DEPTH = 4;
  localparam int CFG_FW    = 4;
  localparam int CFG_W     = 32;
  localparam int SZ_W      = 2;
  localparam int RR_W      = $clog2(ARF_WAYS);

  typedef struct packed {
    logic              valid;
    logic [VPN_W-1:0]  vpn;
    logic [VPN_W-1:0]  ppn;
    logic [ASID_W-1:0] asid;
    logic [CA_W-1:0]   attr;
  } tlb_entry_t;
endpackage

// File: rtl/itlb_way.sv
module itlb_way
  import itlb_pkg::*;
#(
  parameter int ENTRIES  = 4,
  parameter bit VAR_SIZE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  tlb_entry_t        wdata,
  input  logic [VA_W-1:0]   va,
  input  logic [ASID_W-1:0] asid,
  input  logic [SZ_W-1:0]   size_sel,
  output logic              hit,
  output logic [VA_W-1:0]   paddr,
  output logic [CA_W-1:0]   attr
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [IDX_W-1:0] rsel, wsel;
  tlb_entry_t       ents [ENTRIES];
  tlb_entry_t       sel;
  logic [VPN_W-1:0] va_vpn, lo_mask;
  logic             tag_eq;

  if (ENTRIES > 1) begin : g_idx
    assign rsel = va[PG_MIN +: IDX_W];
    assign wsel = wdata.vpn[IDX_W-1:0];
  end else begin : g_noidx
    assign rsel = '0;
    assign wsel = '0;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    tlb_entry_t ent_q;
    logic       ld;
    assign ld = we && (wsel == IDX_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ent_q <= '0;
      else if (ld) ent_q <= wdata;
    end
    assign ents[e] = ent_q;
  end

  if (VAR_SIZE) begin : g_var
    assign lo_mask = ~({VPN_W{1'b1}} << {size_sel, 1'b0});
  end else begin : g_fix
    logic unused_size;
    assign unused_size = ^size_sel;
    assign lo_mask = '0;
  end

  always_comb begin
    sel    = ents[rsel];
    va_vpn = va[VA_W-1:PG_MIN];
    tag_eq = ((sel.vpn ^ va_vpn) & ~lo_mask) == '0;
    hit    = sel.valid && (sel.asid != '0) && (sel.asid == asid) && tag_eq;
    paddr  = {(sel.ppn & ~lo_mask) | (va_vpn & lo_mask), va[PG_MIN-1:0]};
    attr   = sel.attr;
  end

  // R5: identifier 0 can never produce a match
  a_r5_null_asid: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (asid != '0));
endmodule

// File: rtl/itlb_victim.sv
module itlb_victim
  import itlb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  output logic [RR_W-1:0] ptr
);
  logic [RR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv) ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  a_r9_advance: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (ptr == RR_W'($past(ptr) + 1'b1)));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr));
endmodule

// File: rtl/itlb_resolve.sv
module itlb_resolve
  import itlb_pkg::*;
#(
  parameter int N = NUM_WAYS
) (
  input  logic [N-1:0]            hits,
  input  logic [N-1:0][VA_W-1:0]  paddrs,
  input  logic [N-1:0][CA_W-1:0]  attrs,
  output logic                    one,
  output logic                    none,
  output logic                    many,
  output logic [VA_W-1:0]         paddr,
  output logic [CA_W-1:0]         attr
);
  localparam int CNT_W = $clog2(N + 1);
  logic [CNT_W-1:0] cnt;
  logic [VA_W-1:0]  pa_or;
  logic [CA_W-1:0]  at_or;

  always_comb begin
    cnt   = '0;
    pa_or = '0;
    at_or = '0;
    for (int i = 0; i < N; i++) begin
      cnt = cnt + CNT_W'(hits[i]);
      if (hits[i]) begin
        pa_or = pa_or | paddrs[i];
        at_or = at_or | attrs[i];
      end
    end
    none  = (cnt == '0);
    one   = (cnt == CNT_W'(1));
    many  = !none && !one;
    paddr = one ? pa_or : '0;
    attr  = one ? at_or : '0;
  end
endmodule

// File: rtl/itlb.sv
module itlb
  import itlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [CFG_W-1:0]  cfg_pgsz,
  input  logic              wr_en,
  input  logic              wr_refill,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [VPN_W-1:0]  wr_ppn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [CA_W-1:0]   wr_attr,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_miss,
  output logic              res_multihit,
  output logic [VA_W-1:0]   res_paddr,
  output logic [CA_W-1:0]   res_attr,
  output logic [RR_W-1:0]   refill_way
);
  tlb_entry_t                    wdata;
  logic                          refill_wr;
  logic [RR_W-1:0]               victim;
  logic [NUM_WAYS-1:0]           way_we, way_hit;
  logic [NUM_WAYS-1:0][VA_W-1:0] way_pa;
  logic [NUM_WAYS-1:0][CA_W-1:0] way_at;
  logic                          r_one, r_none, r_many;
  logic [VA_W-1:0]               r_pa;
  logic [CA_W-1:0]               r_at;
  logic                          unused_cfg;

  assign unused_cfg = ^cfg_pgsz;
  assign refill_wr  = wr_en && wr_refill;
  assign wdata      = '{valid: 1'b1, vpn: wr_vpn, ppn: wr_ppn, asid: wr_asid, attr: wr_attr};

  itlb_victim u_victim (.clk(clk), .rst_n(rst_n), .adv(refill_wr), .ptr(victim));
  assign refill_way = victim;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    localparam bit IS_ARF = (w < ARF_WAYS);
    localparam bit IS_VAR = (w >= ARF_WAYS) && (w < NUM_WAYS - 1);
    assign way_we[w] = wr_en && (wr_refill ? (IS_ARF && (victim == RR_W'(w)))
                                           : (wr_way == WAY_W'(w)));
    itlb_way #(.ENTRIES(IS_ARF ? ARF_DEPTH : 1), .VAR_SIZE(IS_VAR)) u_way (
      .clk(clk), .rst_n(rst_n), .we(way_we[w]), .wdata(wdata),
      .va(lk_vaddr), .asid(lk_asid), .size_sel(cfg_pgsz[CFG_FW*w +: SZ_W]),
      .hit(way_hit[w]), .paddr(way_pa[w]), .attr(way_at[w]));
  end

  itlb_resolve u_resolve (
    .hits(way_hit), .paddrs(way_pa), .attrs(way_at),
    .one(r_one), .none(r_none), .many(r_many), .paddr(r_pa), .attr(r_at));

  logic            v_d, h_d, m_d, mh_d;
  logic [VA_W-1:0] pa_d;
  logic [CA_W-1:0] at_d;

  always_comb begin
    v_d  = lk_valid;
    h_d  = lk_valid && r_one;
    m_d  = lk_valid && r_none;
    mh_d = lk_valid && r_many;
    pa_d = h_d ? r_pa : '0;
    at_d = h_d ? r_at : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_hit      <= 1'b0;
      res_miss     <= 1'b0;
      res_multihit <= 1'b0;
      res_paddr    <= '0;
      res_attr     <= '0;
    end else begin
      res_valid    <= v_d;
      res_hit      <= h_d;
      res_miss     <= m_d;
      res_multihit <= mh_d;
      res_paddr    <= pa_d;
      res_attr     <= at_d;
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!res_valid && !res_hit && !res_miss && !res_multihit));
  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot({res_hit, res_miss, res_multihit}));
  a_r2_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> (res_paddr[PG_MIN-1:0] == $past(lk_vaddr[PG_MIN-1:0])));
  a_r3_fail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_miss || res_multihit) |-> (res_paddr == '0 && res_attr == '0));
  a_r11_way7_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_refill && wr_way == WAY_W'(NUM_WAYS)) |-> (way_we == '0));
endmodule

// File: tb/itlb_tb.sv
`timescale 1ns/1ps
module itlb_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, wr_en, wr_refill;
  logic [31:0] lk_vaddr, cfg_pgsz;
  logic [7:0]  lk_asid, wr_asid;
  logic [2:0]  wr_way;
  logic [19:0] wr_vpn, wr_ppn;
  logic [3:0]  wr_attr;
  logic        res_valid, res_hit, res_miss, res_multihit;
  logic [31:0] res_paddr;
  logic [3:0]  res_attr;
  logic [1:0]  refill_way;

  always #2.5 clk = ~clk;

  itlb u_dut (.*);

  // behavioural model
  logic        m_v    [0:6][0:3];
  logic [19:0] m_vpn  [0:6][0:3];
  logic [19:0] m_ppn  [0:6][0:3];
  logic [7:0]  m_asid [0:6][0:3];
  logic [3:0]  m_attr [0:6][0:3];
  int          m_ptr;
  logic        e_valid, e_hit, e_miss, e_multi;
  logic [31:0] e_pa;
  logic [3:0]  e_at;
  string       e_tag;
  logic [31:0] cfg_nx;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit lv, input logic [31:0] va, input logic [7:0] las,
                      input bit we, input bit rf, input logic [2:0] way,
                      input logic [19:0] vpn, input logic [19:0] ppn,
                      input logic [7:0] was, input logic [3:0] at, input string tag);
    int cnt, w, idx, lg;
    logic [31:0] mask, pa;
    @(negedge clk);
    chk(e_tag, "valid",    {31'b0, res_valid},    {31'b0, e_valid});
    chk(e_tag, "hit",      {31'b0, res_hit},      {31'b0, e_hit});
    chk(e_tag, "miss",     {31'b0, res_miss},     {31'b0, e_miss});
    chk(e_tag, "multihit", {31'b0, res_multihit}, {31'b0, e_multi});
    chk(e_tag, "paddr",    res_paddr,             e_pa);
    chk(e_tag, "attr",     {28'b0, res_attr},     {28'b0, e_at});
    chk(e_tag, "refill_way (R9)", {30'b0, refill_way}, m_ptr);
    lk_valid = lv; lk_vaddr = va; lk_asid = las; cfg_pgsz = cfg_nx;
    wr_en = we; wr_refill = rf; wr_way = way; wr_vpn = vpn; wr_ppn = ppn;
    wr_asid = was; wr_attr = at;
    // expected lookup result from contents before this cycle's write (R10)
    cnt = 0; pa = 0; e_at = 0;
    for (int k = 0; k < 7; k++) begin
      lg = 12;
      if (k == 4 || k == 5) lg = 12 + 2 * int'(cfg_nx[4*k +: 2]);
      idx = (k < 4) ? int'(va[13:12]) : 0;
      if (m_v[k][idx] && m_asid[k][idx] != 0 && m_asid[k][idx] == las &&
          (va >> lg) == ({m_vpn[k][idx], 12'h0} >> lg)) begin
        cnt++;
        mask = (32'h1 << lg) - 1;
        pa = ({m_ppn[k][idx], 12'h0} & ~mask) | (va & mask);
        e_at = m_attr[k][idx];
      end
    end
    e_valid = lv;
    e_hit   = lv && cnt == 1;
    e_miss  = lv && cnt == 0;
    e_multi = lv && cnt > 1;
    e_pa    = e_hit ? pa : 0;
    if (!e_hit) e_at = 0;
    e_tag = tag;
    if (we) begin
      w = rf ? m_ptr : int'(way);
      if (rf) m_ptr = (m_ptr + 1) % 4;
      if (w < 7) begin
        idx = (w < 4) ? int'(vpn[1:0]) : 0;
        m_v[w][idx] = 1; m_vpn[w][idx] = vpn; m_ppn[w][idx] = ppn;
        m_asid[w][idx] = was; m_attr[w][idx] = at;
      end
    end
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] as, input string tag);
    step(1, va, as, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic wr(input logic [2:0] way, input logic [19:0] vpn, input logic [19:0] ppn,
                    input logic [7:0] as, input logic [3:0] at, input string tag);
    step(0, 0, 0, 1, 0, way, vpn, ppn, as, at, tag);
  endtask
  task automatic refill(input logic [19:0] vpn, input logic [19:0] ppn, input logic [7:0] as, input string tag);
    step(0, 0, 0, 1, 1, 3'd5, vpn, ppn, as, 4'h9, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 7; a++)
      for (int b = 0; b < 4; b++) begin
        m_v[a][b] = 0; m_vpn[a][b] = 0; m_ppn[a][b] = 0; m_asid[a][b] = 0; m_attr[a][b] = 0;
      end
    m_ptr = 0; cfg_nx = 0;
    e_valid = 0; e_hit = 0; e_miss = 0; e_multi = 0; e_pa = 0; e_at = 0; e_tag = "R1 reset";
    rst_n = 0; lk_valid = 0; lk_vaddr = 0; lk_asid = 0; cfg_pgsz = 0;
    wr_en = 0; wr_refill = 0; wr_way = 0; wr_vpn = 0; wr_ppn = 0; wr_asid = 0; wr_attr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 idle");
    look(32'h12345abc, 8'd5, "R3 empty miss");
    // R10: write and lookup in one cycle, old contents seen
    step(1, 32'h12345abc, 8'd5, 1, 0, 3'd0, 20'h12345, 20'hABCDE, 8'd5, 4'h3, "R10 same cycle");
    look(32'h12345abc, 8'd5, "R2 single hit");
    look(32'h12345abc, 8'd6, "R5 asid mismatch");
    look(32'h12344abc, 8'd5, "R6 other index");
    wr(3'd1, 20'h12345, 20'h11111, 8'd5, 4'h7, "R4 load");
    look(32'h12345abc, 8'd5, "R4 multihit");
    wr(3'd2, 20'h00007, 20'h00007, 8'd0, 4'h1, "R5 load null");
    look(32'h00007010, 8'd0, "R5 null asid");
    wr(3'd3, 20'h00010, 20'h20000, 8'd5, 4'h2, "R6 load a");
    wr(3'd3, 20'h00011, 20'h20001, 8'd5, 4'h4, "R6 load b");
    look(32'h00010008, 8'd5, "R6 index 0");
    look(32'h00011008, 8'd5, "R6 index 1");
    wr(3'd3, 20'h00014, 20'h20004, 8'd5, 4'h6, "R6 replace");
    look(32'h00010008, 8'd5, "R6 replaced miss");
    look(32'h00014008, 8'd5, "R6 replaced hit");
    cfg_nx = 32'h0001_0000;
    wr(3'd4, 20'h40001, 20'h80003, 8'd5, 4'hA, "R7 load 16K");
    look(32'h40002abc, 8'd5, "R7 16K hit");
    cfg_nx = 32'h0031_0000;
    wr(3'd5, 20'h50000, 20'h90000, 8'd5, 4'hB, "R7 load 256K");
    look(32'h5003f123, 8'd5, "R7 256K hit");
    cfg_nx = 32'h0035_0000;
    look(32'h40002abc, 8'd5, "R7 upper field bits");
    cfg_nx = 32'h0F35_3333;
    wr(3'd6, 20'h60001, 20'h70001, 8'd1, 4'hC, "R8 load wired");
    look(32'h60000123, 8'd1, "R8 wired neighbour miss");
    look(32'h60001123, 8'd1, "R8 wired hit");
    look(32'h00014008, 8'd5, "R8 refill way fixed size");
    for (int i = 0; i < 5; i++)
      refill(20'h30000 + 20'(i), 20'h31000 + 20'(i), 8'd7, "R9 refill");
    look(32'h30000000, 8'd7, "R9 overwritten");
    look(32'h30004000, 8'd7, "R9 wrapped");
    look(32'h30002000, 8'd7, "R9 third");
    look(32'h5003f123, 8'd5, "R9 wr_way ignored");
    look(32'h12345abc, 8'd5, "R9 way1 replaced");
    wr(3'd7, 20'h77777, 20'h12121, 8'd5, 4'hF, "R11 way 7");
    look(32'h77777000, 8'd5, "R11 no entry");
    look(32'h60001123, 8'd1, "R11 wired kept");
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom % 4);
      if ($urandom % 8 == 0) cfg_nx = $urandom;
      case (op)
        0, 1: look({20'h00100 + 20'($urandom % 8), 12'($urandom)}, 8'($urandom % 3), "RND R2/R3/R4");
        2:    wr(3'($urandom % 8), 20'h00100 + 20'($urandom % 8), 20'($urandom), 8'($urandom % 3), 4'($urandom), "RND R11");
        default: refill(20'h00100 + 20'($urandom % 8), 20'($urandom), 8'($urandom % 3), "RND R9");
      endcase
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 end");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 end");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule